// File: doc/BRIEF.md
# Power-On Configuration Strap Capture and Select

This block sits between a set of dual-use pads and the clock-generation core of a clock synthesiser. While power-on reset is held, the pads are plain inputs whose resistor-set levels carry configuration. The block stores those levels once, when reset is released. From then on it turns the pads into outputs, and they stay outputs until the next reset.

From the stored configuration the block derives several selections:

- the 4-bit frequency code that picks the CPU, SDRAM and PCI frequency set;
- the peripheral (SIO) clock frequency;
- the CPU output buffer voltage;
- the role of four power-management pads, which are either SDRAM clock outputs or active-low stop and power-down inputs.

A register interface can override the frequency code. One source bit picks either the stored strap code or a code written by software.

Top module: `strap_latch_top`

## Requirements
- R1: While `rst_ni` is low, `pad_oe_o` is all zeros and `strap_o` is all zeros, whatever the pad levels are.
- R2: At the first rising edge of `clk_i` with `rst_ni` high, `strap_o` takes the value of `strap_pins_i` and `pad_oe_o` becomes all ones, both at that same edge. The strap layout is: bit 6 = CPU buffer voltage, bit 5 = SIO select, bit 4 = desktop mode, bits 3:0 = {SDRAM-follows-CPU, FS2, FS1, FS0}.
- R3: After the capture edge, `strap_o` does not follow later changes on `strap_pins_i`, and `pad_oe_o` stays all ones until reset is asserted again.
- R4: Asserting reset again clears the capture. The next release captures the pad levels present at that new release edge.
- R5: When `freq_src_reg_i` is 0, `freq_code_o` equals `strap_o[3:0]`.
- R6: When `freq_src_reg_i` is 1, `freq_code_o` equals `reg_freq_code_i`. That input is formed as {byte 0 bit 2, byte 0 bits 6:4} of the control register.
- R7: After capture with strap bit 4 = 1 (desktop), `pm_sdram_en_o` = 1, `pm_oe_o` is all ones and `pm_ctrl_n_o` is all ones (inactive).
- R8: After capture with strap bit 4 = 0 (mobile), `pm_sdram_en_o` = 0, `pm_oe_o` is all zeros and `pm_ctrl_n_o` equals `pm_pins_i`. The bit order is 0 = CPU stop, 1 = PCI stop, 2 = SDRAM stop, 3 = power-down, all active low.
- R9: Before capture, `pm_ctrl_n_o` is all ones and `pm_oe_o` and `pm_sdram_en_o` are zero.
- R10: `sio_24m_o` equals strap bit 5 (1 = 24 MHz, 0 = 14.318 MHz). `cpu_2v5_o` equals strap bit 6 (1 = 2.5 V buffers, 0 = 3.3 V).
- R11: `sdram_eq_cpu_o` equals `freq_code_o[3]`. A 1 means the SDRAM clock runs at the CPU frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| strap_pins_i | input | 7 | Levels seen on the shared strap pads |
| freq_src_reg_i | input | 1 | Frequency source: 0 = straps, 1 = register |
| reg_freq_code_i | input | 4 | Software-written frequency code |
| pm_pins_i | input | 4 | Levels on the power-management pads |
| strap_o | output | 7 | Stored strap word |
| pad_oe_o | output | 7 | Output enables of the shared strap pads |
| freq_code_o | output | 4 | Resolved frequency code |
| sdram_eq_cpu_o | output | 1 | SDRAM frequency equals CPU frequency |
| sio_24m_o | output | 1 | SIO clock is 24 MHz |
| cpu_2v5_o | output | 1 | CPU buffers run at 2.5 V |
| pm_sdram_en_o | output | 1 | Power-management pads act as SDRAM clocks |
| pm_oe_o | output | 4 | Output enables of the power-management pads |
| pm_ctrl_n_o | output | 4 | Active-low stop and power-down controls |

## Verification
The stimulus runs three power-on cycles with different strap words. The words mix mobile and desktop, both SIO choices and both voltage choices, so that every derived output is seen at both levels. Strap and management pad levels are toggled during reset and after capture. This tells a correct single capture at the release edge apart from a latch that keeps tracking the pads or that captures one edge late. The frequency source bit is switched back and forth while the software code changes, which separates the strap path from the register path. Checks while reset is held and just after release cover the input-only window and the forced-inactive management controls.

// File: rtl/strap_pkg.sv
package strap_pkg;
  parameter int unsigned FREQ_W = 4;
  parameter int unsigned PM_W   = 4;
  localparam int unsigned STRAP_W = FREQ_W + 3;

  typedef struct packed {
    logic              cpu_2v5;
    logic              sio_24m;
    logic              desktop;
    logic [FREQ_W-1:0] freq;
  } strap_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] strap_o,
  output logic         released_o
);
  logic [W-1:0] strap_q;
  logic         released_q;

  // one-shot capture on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      released_q <= 1'b0;
      strap_q    <= '0;
    end else if (!released_q) begin
      released_q <= 1'b1;
      strap_q    <= pins_i;
    end
  end

  assign strap_o    = strap_q;
  assign released_o = released_q;

  assert_capture_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !released_q |=> released_q);
  assert_strap_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    released_q |=> $stable(strap_q));
  assert_release_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    released_q |=> released_q);
endmodule

// File: rtl/freq_code_sel.sv
module freq_code_sel #(
  parameter int unsigned FREQ_W = 4
) (
  input  logic              src_reg_i,
  input  logic [FREQ_W-1:0] strap_code_i,
  input  logic [FREQ_W-1:0] reg_code_i,
  output logic [FREQ_W-1:0] code_o,
  output logic              sdram_eq_cpu_o
);
  always_comb begin
    code_o = src_reg_i ? reg_code_i : strap_code_i;
  end

  // MSB of the code: SDRAM tracks CPU frequency
  assign sdram_eq_cpu_o = code_o[FREQ_W-1];
endmodule

// File: rtl/pm_pin_route.sv
module pm_pin_route #(
  parameter int unsigned PM_W = 4
) (
  input  logic            released_i,
  input  logic            desktop_i,
  input  logic [PM_W-1:0] pins_i,
  output logic            sdram_en_o,
  output logic [PM_W-1:0] oe_o,
  output logic [PM_W-1:0] ctrl_n_o
);
  logic mobile_live;
  logic desk_live;

  assign mobile_live = released_i & ~desktop_i;
  assign desk_live   = released_i &  desktop_i;
  assign sdram_en_o  = desk_live;

  for (genvar i = 0; i < PM_W; i++) begin : g_pin
    assign oe_o[i]     = desk_live;
    assign ctrl_n_o[i] = mobile_live ? pins_i[i] : 1'b1;
  end
endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
  import strap_pkg::*;
#(
  parameter int unsigned FW = strap_pkg::FREQ_W,
  parameter int unsigned PW = strap_pkg::PM_W,
  localparam int unsigned SW = FW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] strap_pins_i,
  input  logic          freq_src_reg_i,
  input  logic [FW-1:0] reg_freq_code_i,
  input  logic [PW-1:0] pm_pins_i,
  output logic [SW-1:0] strap_o,
  output logic [SW-1:0] pad_oe_o,
  output logic [FW-1:0] freq_code_o,
  output logic          sdram_eq_cpu_o,
  output logic          sio_24m_o,
  output logic          cpu_2v5_o,
  output logic          pm_sdram_en_o,
  output logic [PW-1:0] pm_oe_o,
  output logic [PW-1:0] pm_ctrl_n_o
);
  logic [SW-1:0] strap_w;
  logic          released;
  logic          desktop;
  logic [FW-1:0] strap_code;

  strap_capture #(.W(SW)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pins_i     (strap_pins_i),
    .strap_o    (strap_w),
    .released_o (released)
  );

  // field split: [SW-1] voltage, [SW-2] sio, [SW-3] mode, [FW-1:0] code
  assign strap_code = strap_w[FW-1:0];
  assign desktop    = strap_w[SW-3];
  assign sio_24m_o  = strap_w[SW-2];
  assign cpu_2v5_o  = strap_w[SW-1];
  assign strap_o    = strap_w;
  assign pad_oe_o   = {SW{released}};

  freq_code_sel #(.FREQ_W(FW)) u_freq (
    .src_reg_i      (freq_src_reg_i),
    .strap_code_i   (strap_code),
    .reg_code_i     (reg_freq_code_i),
    .code_o         (freq_code_o),
    .sdram_eq_cpu_o (sdram_eq_cpu_o)
  );

  pm_pin_route #(.PM_W(PW)) u_pm (
    .released_i (released),
    .desktop_i  (desktop),
    .pins_i     (pm_pins_i),
    .sdram_en_o (pm_sdram_en_o),
    .oe_o       (pm_oe_o),
    .ctrl_n_o   (pm_ctrl_n_o)
  );

  assert_oe_freezes_strap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[0] |=> $stable(strap_o));
  assert_strap_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freq_src_reg_i |-> freq_code_o == strap_o[FW-1:0]);
  assert_desk_inactive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[0] && strap_o[SW-3]) |-> (pm_ctrl_n_o == '1 && pm_oe_o == '1));
  assert_mobile_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[0] && !strap_o[SW-3]) |-> (pm_ctrl_n_o == pm_pins_i && pm_oe_o == '0));
  assert_prerelease_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[0] |-> (pm_ctrl_n_o == '1 && !pm_sdram_en_o));
endmodule

// File: tb/strap_latch_top_tb.sv
module strap_latch_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pins = '0;
  logic       src_reg = 1'b0;
  logic [3:0] reg_code = '0;
  logic [3:0] pm_pins = 4'hF;

  logic [6:0] strap_o, pad_oe_o;
  logic [3:0] freq_code_o, pm_oe_o, pm_ctrl_n_o;
  logic       sdram_eq_cpu_o, sio_24m_o, cpu_2v5_o, pm_sdram_en_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  strap_latch_top u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .strap_pins_i    (pins),
    .freq_src_reg_i  (src_reg),
    .reg_freq_code_i (reg_code),
    .pm_pins_i       (pm_pins),
    .strap_o         (strap_o),
    .pad_oe_o        (pad_oe_o),
    .freq_code_o     (freq_code_o),
    .sdram_eq_cpu_o  (sdram_eq_cpu_o),
    .sio_24m_o       (sio_24m_o),
    .cpu_2v5_o       (cpu_2v5_o),
    .pm_sdram_en_o   (pm_sdram_en_o),
    .pm_oe_o         (pm_oe_o),
    .pm_ctrl_n_o     (pm_ctrl_n_o)
  );

  // behavioural reference
  bit         rel_m = 0;
  logic [6:0] strap_m = '0;
  int         rel_age = 0;
  int         boot_n = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_m   <= 0;
      strap_m <= '0;
      rel_age <= 0;
    end else if (!rel_m) begin
      rel_m   <= 1;
      strap_m <= pins;
      rel_age <= 0;
      boot_n  <= boot_n + 1;
    end else begin
      rel_age <= rel_age + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string      t_cap;
    logic [3:0] code_e;
    bit         desk;
    cycles++;
    if (!rel_m)            t_cap = "R1";
    else if (rel_age == 0) t_cap = (boot_n > 1) ? "R4" : "R2";
    else                   t_cap = "R3";
    chk({t_cap, " strap"}, 32'(strap_o), 32'(strap_m));
    chk({t_cap, " pad_oe"}, 32'(pad_oe_o), rel_m ? 32'h7F : 32'h0);
    code_e = src_reg ? reg_code : strap_m[3:0];
    chk(src_reg ? "R6 freq" : "R5 freq", 32'(freq_code_o), 32'(code_e));
    chk("R11 sdram_eq_cpu", 32'(sdram_eq_cpu_o), 32'(code_e[3]));
    chk("R10 sio", 32'(sio_24m_o), 32'(strap_m[5]));
    chk("R10 cpu_v", 32'(cpu_2v5_o), 32'(strap_m[6]));
    desk = strap_m[4];
    if (!rel_m) begin
      chk("R9 pm_ctrl", 32'(pm_ctrl_n_o), 32'hF);
      chk("R9 pm_oe", 32'(pm_oe_o), 32'h0);
      chk("R9 sdram_en", 32'(pm_sdram_en_o), 32'h0);
    end else if (desk) begin
      chk("R7 pm_ctrl", 32'(pm_ctrl_n_o), 32'hF);
      chk("R7 pm_oe", 32'(pm_oe_o), 32'hF);
      chk("R7 sdram_en", 32'(pm_sdram_en_o), 32'h1);
    end else begin
      chk("R8 pm_ctrl", 32'(pm_ctrl_n_o), 32'(pm_pins));
      chk("R8 pm_oe", 32'(pm_oe_o), 32'h0);
      chk("R8 sdram_en", 32'(pm_sdram_en_o), 32'h0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wiggle(input int n, input bit use_reg);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      pins     = 7'($urandom);
      pm_pins  = 4'($urandom);
      reg_code = 4'($urandom);
      src_reg  = use_reg ? 1'($urandom) : 1'b0;
    end
  endtask

  task automatic boot(input logic [6:0] straps);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      pins    = 7'($urandom);
      pm_pins = 4'($urandom);
    end
    pins = straps;
    step(1);
    rst_n = 1'b1;
  endtask

  initial begin
    step(2);
    boot(7'b110_0110);      // mobile, 24 MHz SIO, 2.5 V, code 0110
    wiggle(20, 0);
    wiggle(30, 1);
    boot(7'b001_1011);      // desktop, 14.318 MHz, 3.3 V, code 1011
    wiggle(15, 0);
    wiggle(25, 1);
    boot(7'b101_1111);      // desktop, 14.318 MHz, 2.5 V, code 1111
    wiggle(20, 1);
    src_reg = 1'b0;
    step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog act=%0d exp=<5000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule